// File: doc/BRIEF.md
# Block-Store Request Validator and Sequencer

This block takes a single block-store request, decides whether it may run, and if so breaks it into a run of 8-byte writes toward a downstream write port. A request has a 64-bit control word, a 64-bit target offset and a source address, and it is accompanied by the state of the addressed function. The block checks the request against a fixed order of rules. The first rule that fails decides the outcome: a condition code, a status code, or an exception type. When every rule passes, the block issues the writes one at a time. It stops at the first write that fails, and it reports success when the last write completes.

The block does not fetch the source data. It presents the index of the doubleword it needs, and the data for that index comes back on an input in the same cycle. Whether the target region is valid is decided downstream. The block presents the address space, offset and length of the request, and a single ok bit comes back. The maximum block length is a register inside the block that can be programmed from a configuration strobe.

Top module: `blkstore_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `done` and `wr_valid` are 0.
- R2: The control word holds the function handle in bits 63:32, the address-space index in bits 19:16 and the byte length in bits 7:0. The enable bit is handle bit 31 (control bit 63). If it is 0, the request ends with cc=3, status 8'h00 and exception 0, and no write is issued. This outcome ranks above every other outcome. `rgn_space`, `rgn_offset` and `rgn_len` show the decoded fields of the accepted request while the block is busy.
- R3: `fn_state` is encoded 0 active, 1 error, 2 permanent error and 3 offline. For state 1 or 2 the request ends with cc=1 and status 8'h08, with no write, and this check ranks above R4 and R5. State 0 and state 3 do not block the request.
- R4: An address-space index greater than 5 ends the request with cc=1 and status 8'h0A, with no write. This check ranks above R5.
- R5: A specification exception (exception code 1, with cc=0 and status 8'h00) ends the request with no write when any of the following holds: the offset is not a multiple of 8, the source address is not a multiple of 8, or the length is 8 or less or not a multiple of 8.
- R6: A length greater than the maximum block length also gives the specification exception. The maximum resets to 128. While `cfg_max_we` is 1, the value on `cfg_max_len` is loaded into it at the clock edge.
- R7: A specification exception is also raised when the low 12 bits of the offset plus the length exceed 4096. A block that ends exactly on the 4 KiB boundary is allowed.
- R8: If the specification checks pass and `rgn_ok` is 0, the request ends with an operand exception (exception code 2) and no write.
- R9: A request that passes all checks issues length/8 writes. Write i has address offset+8*i for i = 0, 1, 2 and so on, and its data is `src_data` presented for `src_idx` = i. Each write holds `wr_valid`, its address and its data until `wr_ready` is seen. The next write is not issued until the response to the current one has arrived.
- R10: A write response with `wr_resp_err`=1 stops the sequence. No further write is issued, and the request ends with the operand exception.
- R11: If all writes respond without error, the request ends with cc=0, status 8'h00 and exception 0.
- R12: `req_ready` is 1 only while the block is idle, so no request is accepted while the block is busy. `done` is a one-cycle pulse, and the result fields are valid while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_ctrl | input | 64 | Control word (handle, address space, length) |
| req_offset | input | 64 | Target offset of the block |
| req_src | input | 64 | Source address, used for the alignment check |
| fn_state | input | 2 | State of the addressed function |
| cfg_max_we | input | 1 | Load strobe for the maximum block length |
| cfg_max_len | input | MAXLEN_W | New maximum block length in bytes |
| rgn_space | output | 4 | Address-space index of the accepted request |
| rgn_offset | output | 64 | Offset of the accepted request |
| rgn_len | output | 8 | Length of the accepted request |
| rgn_ok | input | 1 | Downstream verdict that the region access is valid |
| src_idx | output | 5 | Index of the source doubleword needed |
| src_data | input | 64 | Source doubleword for `src_idx` |
| wr_valid | output | 1 | Write offered |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 64 | Write address |
| wr_data | output | 64 | Write data |
| wr_resp_valid | input | 1 | Write response strobe |
| wr_resp_err | input | 1 | Write response carries an error |
| done | output | 1 | One-cycle completion pulse |
| done_cc | output | 2 | Condition code |
| done_status | output | 8 | Status code |
| done_exc | output | 2 | Exception type: 0 none, 1 specification, 2 operand |

## Verification
The assertions check the handshake rules on every cycle. They confirm that `done` lasts one cycle and that `req_ready` falls after an accept. They confirm that a stalled write keeps its address and data, that write addresses stay 8-byte aligned, that only one write is outstanding, and that an idle block writes nothing. They also check how the result fields are combined: an exception comes with cc=0 and no status, and an invalid handle comes with neither a status nor an exception. Only the bench scenarios can show the ranking among errors when several rules fail at once. The same holds for the exact length and page-boundary edges, the effect of reprogramming the maximum length, and the addresses, data and count of writes when a write fails partway through a block.

// File: rtl/bsv_pkg.sv
`timescale 1ns/1ps
package bsv_pkg;

    localparam int CTRL_W     = 64;
    localparam int ADDR_W     = 64;
    localparam int DATA_W     = 64;
    localparam int HANDLE_W   = 32;
    localparam int SPACE_W    = 4;
    localparam int LEN_W      = 8;
    localparam int HANDLE_LSB = 32;
    localparam int SPACE_LSB  = 16;
    localparam int LEN_LSB    = 0;
    localparam int ENABLE_BIT = 31;
    localparam int BEAT_BYTES = 8;
    localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
    localparam int PAGE_BYTES = 4096;
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam int BEAT_IDX_W = LEN_W - BEAT_SHIFT;
    localparam int STATUS_W   = 8;

    localparam logic [SPACE_W-1:0]  MAX_SPACE    = 4'd5;
    localparam logic [STATUS_W-1:0] ST_NONE      = 8'h00;
    localparam logic [STATUS_W-1:0] ST_BLOCKED   = 8'h08;
    localparam logic [STATUS_W-1:0] ST_BAD_SPACE = 8'h0A;

    typedef enum logic [1:0] {
        CC_OK         = 2'd0,
        CC_STATUS     = 2'd1,
        CC_RSVD       = 2'd2,
        CC_BAD_HANDLE = 2'd3
    } cc_e;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_SPEC = 2'd1,
        EXC_OPER = 2'd2,
        EXC_RSVD = 2'd3
    } exc_e;

    typedef enum logic [1:0] {
        FN_ACTIVE     = 2'd0,
        FN_ERROR      = 2'd1,
        FN_PERM_ERROR = 2'd2,
        FN_OFFLINE    = 2'd3
    } fn_state_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CHECK = 3'd1,
        PH_ISSUE = 3'd2,
        PH_WAIT  = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    typedef struct packed {
        logic [HANDLE_W-1:0] handle;
        logic [SPACE_W-1:0]  space;
        logic [LEN_W-1:0]    len;
    } ctrl_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [ADDR_W-1:0]  offset;
        logic [ADDR_W-1:0]  src;
        fn_state_e          fstate;
    } req_t;

    typedef struct packed {
        cc_e                 cc;
        logic [STATUS_W-1:0] status;
        exc_e                exc;
    } result_t;

    function automatic ctrl_t split_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.handle = w[HANDLE_LSB +: HANDLE_W];
        c.space  = w[SPACE_LSB +: SPACE_W];
        c.len    = w[LEN_LSB +: LEN_W];
        return c;
    endfunction

    function automatic result_t mk_result(input cc_e cc,
                                          input logic [STATUS_W-1:0] st,
                                          input exc_e exc);
        result_t r;
        r.cc     = cc;
        r.status = st;
        r.exc    = exc;
        return r;
    endfunction

endpackage

// File: rtl/bsv_maxlen_reg.sv
`timescale 1ns/1ps
module bsv_maxlen_reg #(
    parameter int W         = 16,
    parameter int RESET_VAL = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= W'(RESET_VAL);
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/bsv_rule_eval.sv
`timescale 1ns/1ps
module bsv_rule_eval
    import bsv_pkg::*;
#(
    parameter int MAXLEN_W = 16
) (
    input  req_t                req,
    input  logic [MAXLEN_W-1:0] max_len,
    input  logic                region_ok,
    output logic                fail,
    output result_t             res
);
    localparam int CMP_W = (MAXLEN_W > LEN_W) ? MAXLEN_W : LEN_W;
    localparam int PG_W  = PAGE_SHIFT + 1;

    logic             handle_off;
    logic             fn_blocked;
    logic             space_bad;
    logic             off_misalign;
    logic             src_misalign;
    logic             len_short;
    logic             len_odd;
    logic             len_over;
    logic             page_cross;
    logic             spec_bad;
    logic [CMP_W-1:0] len_c;
    logic [CMP_W-1:0] max_c;
    logic [PG_W-1:0]  page_end;

    assign handle_off   = !req.ctrl.handle[ENABLE_BIT];
    assign fn_blocked   = (req.fstate == FN_ERROR) || (req.fstate == FN_PERM_ERROR);
    assign space_bad    = req.ctrl.space > MAX_SPACE;
    assign off_misalign = |req.offset[BEAT_SHIFT-1:0];
    assign src_misalign = |req.src[BEAT_SHIFT-1:0];
    assign len_short    = req.ctrl.len <= LEN_W'(BEAT_BYTES);
    assign len_odd      = |req.ctrl.len[BEAT_SHIFT-1:0];
    assign len_c        = CMP_W'(req.ctrl.len);
    assign max_c        = CMP_W'(max_len);
    assign len_over     = len_c > max_c;
    assign page_end     = {1'b0, req.offset[PAGE_SHIFT-1:0]} + PG_W'(req.ctrl.len);
    assign page_cross   = page_end > PG_W'(PAGE_BYTES);
    assign spec_bad     = off_misalign || src_misalign || len_short || len_odd
                        || len_over || page_cross;

    // Fixed ranking: handle, function state, space, specification, region.
    always_comb begin
        fail = 1'b1;
        res  = mk_result(CC_OK, ST_NONE, EXC_NONE);
        if (handle_off) begin
            res = mk_result(CC_BAD_HANDLE, ST_NONE, EXC_NONE);
        end else if (fn_blocked) begin
            res = mk_result(CC_STATUS, ST_BLOCKED, EXC_NONE);
        end else if (space_bad) begin
            res = mk_result(CC_STATUS, ST_BAD_SPACE, EXC_NONE);
        end else if (spec_bad) begin
            res = mk_result(CC_OK, ST_NONE, EXC_SPEC);
        end else if (!region_ok) begin
            res = mk_result(CC_OK, ST_NONE, EXC_OPER);
        end else begin
            fail = 1'b0;
        end
    end

    logic unused_rule;
    assign unused_rule = ^{req.ctrl.handle, req.offset, req.src};
endmodule

// File: rtl/bsv_beat_gen.sv
`timescale 1ns/1ps
module bsv_beat_gen
    import bsv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [ADDR_W-1:0]     base,
    input  logic [LEN_W-1:0]      len,
    input  logic                  advance,
    output logic [BEAT_IDX_W-1:0] idx,
    output logic [ADDR_W-1:0]     addr,
    output logic                  last
);
    logic [BEAT_IDX_W-1:0] idx_q;
    logic [BEAT_IDX_W-1:0] last_idx_q;
    logic [ADDR_W-1:0]     base_q;
    logic [LEN_W-1:0]      beats_m1;

    assign beats_m1 = (len >> BEAT_SHIFT) - LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            last_idx_q <= '0;
            base_q     <= '0;
        end else if (load) begin
            idx_q      <= '0;
            last_idx_q <= beats_m1[BEAT_IDX_W-1:0];
            base_q     <= base;
        end else if (advance) begin
            idx_q <= idx_q + BEAT_IDX_W'(1);
        end
    end

    assign idx  = idx_q;
    assign addr = base_q + (ADDR_W'(idx_q) << BEAT_SHIFT);
    assign last = (idx_q == last_idx_q);

    logic unused_beat;
    assign unused_beat = ^beats_m1;
endmodule

// File: rtl/blkstore_seq.sv
`timescale 1ns/1ps
module blkstore_seq
    import bsv_pkg::*;
#(
    parameter int MAXLEN_W     = 16,
    parameter int MAXLEN_RESET = 128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [CTRL_W-1:0]     req_ctrl,
    input  logic [ADDR_W-1:0]     req_offset,
    input  logic [ADDR_W-1:0]     req_src,
    input  logic [1:0]            fn_state,
    input  logic                  cfg_max_we,
    input  logic [MAXLEN_W-1:0]   cfg_max_len,
    output logic [SPACE_W-1:0]    rgn_space,
    output logic [ADDR_W-1:0]     rgn_offset,
    output logic [LEN_W-1:0]      rgn_len,
    input  logic                  rgn_ok,
    output logic [BEAT_IDX_W-1:0] src_idx,
    input  logic [DATA_W-1:0]     src_data,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    input  logic                  wr_resp_valid,
    input  logic                  wr_resp_err,
    output logic                  done,
    output logic [1:0]            done_cc,
    output logic [STATUS_W-1:0]   done_status,
    output logic [1:0]            done_exc
);
    phase_e                ph_q, ph_d;
    req_t                  req_q, req_in;
    result_t               res_q, res_d, chk_res;
    logic                  res_we;
    logic                  chk_fail;
    logic                  accept;
    logic                  advance;
    logic                  beat_last;
    logic [MAXLEN_W-1:0]   max_len;

    assign accept = req_valid && req_ready;

    always_comb begin
        req_in.ctrl   = split_ctrl(req_ctrl);
        req_in.offset = req_offset;
        req_in.src    = req_src;
        req_in.fstate = fn_state_e'(fn_state);
    end

    bsv_maxlen_reg #(
        .W         (MAXLEN_W),
        .RESET_VAL (MAXLEN_RESET)
    ) u_maxlen (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_max_we),
        .wdata (cfg_max_len),
        .q     (max_len)
    );

    bsv_rule_eval #(
        .MAXLEN_W (MAXLEN_W)
    ) u_rules (
        .req       (req_q),
        .max_len   (max_len),
        .region_ok (rgn_ok),
        .fail      (chk_fail),
        .res       (chk_res)
    );

    bsv_beat_gen u_beats (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .base    (req_offset),
        .len     (req_in.ctrl.len),
        .advance (advance),
        .idx     (src_idx),
        .addr    (wr_addr),
        .last    (beat_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            req_q <= '0;
            res_q <= '0;
        end else begin
            ph_q <= ph_d;
            if (accept) begin
                req_q <= req_in;
            end
            if (res_we) begin
                res_q <= res_d;
            end
        end
    end

    always_comb begin
        ph_d    = ph_q;
        res_we  = 1'b0;
        res_d   = res_q;
        advance = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req_valid) begin
                    ph_d = PH_CHECK;
                end
            end
            PH_CHECK: begin
                if (chk_fail) begin
                    res_we = 1'b1;
                    res_d  = chk_res;
                    ph_d   = PH_DONE;
                end else begin
                    ph_d = PH_ISSUE;
                end
            end
            PH_ISSUE: begin
                if (wr_ready) begin
                    ph_d = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (wr_resp_valid) begin
                    if (wr_resp_err) begin
                        res_we = 1'b1;
                        res_d  = mk_result(CC_OK, ST_NONE, EXC_OPER);
                        ph_d   = PH_DONE;
                    end else if (beat_last) begin
                        res_we = 1'b1;
                        res_d  = mk_result(CC_OK, ST_NONE, EXC_NONE);
                        ph_d   = PH_DONE;
                    end else begin
                        advance = 1'b1;
                        ph_d    = PH_ISSUE;
                    end
                end
            end
            PH_DONE: begin
                ph_d = PH_IDLE;
            end
            default: begin
                ph_d = PH_IDLE;
            end
        endcase
    end

    assign req_ready   = (ph_q == PH_IDLE);
    assign wr_valid    = (ph_q == PH_ISSUE);
    assign wr_data     = src_data;
    assign done        = (ph_q == PH_DONE);
    assign done_cc     = res_q.cc;
    assign done_status = res_q.status;
    assign done_exc    = res_q.exc;
    assign rgn_space   = req_q.ctrl.space;
    assign rgn_offset  = req_q.offset;
    assign rgn_len     = req_q.ctrl.len;

    logic unused_top;
    assign unused_top = ^{req_ctrl, req_q.src, req_q.ctrl.handle};
endmodule

// File: rtl/blkstore_seq_sva.sv
`timescale 1ns/1ps
module blkstore_seq_sva
    import bsv_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                wr_valid,
    input logic                wr_ready,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                done,
    input logic [1:0]          done_cc,
    input logic [STATUS_W-1:0] done_status,
    input logic [1:0]          done_exc
);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!wr_valid && !done));

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R9
    wr_align_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[BEAT_SHIFT-1:0] == '0));

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> !wr_valid);

    // R5
    exc_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_exc != 2'd0) |-> (done_cc == 2'd0 && done_status == 8'h00));

    // R2
    handle_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (done && done_cc == 2'd3) |-> (done_status == 8'h00 && done_exc == 2'd0));
endmodule

bind blkstore_seq blkstore_seq_sva u_sva (.*);

// File: tb/blkstore_seq_tb_top.sv
`timescale 1ns/1ps
module blkstore_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_ctrl;
    logic [63:0] req_offset;
    logic [63:0] req_src;
    logic [1:0]  fn_state;
    logic        cfg_max_we;
    logic [15:0] cfg_max_len;
    logic [3:0]  rgn_space;
    logic [63:0] rgn_offset;
    logic [7:0]  rgn_len;
    logic        rgn_ok;
    logic [4:0]  src_idx;
    logic [63:0] src_data;
    logic        wr_valid;
    logic        wr_ready;
    logic [63:0] wr_addr;
    logic [63:0] wr_data;
    logic        wr_resp_valid;
    logic        wr_resp_err;
    logic        done;
    logic [1:0]  done_cc;
    logic [7:0]  done_status;
    logic [1:0]  done_exc;

    int nchecks = 0;
    int nerrors = 0;
    int model_max = 128;

    always #2.5 clk = ~clk;

    blkstore_seq dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_ctrl(req_ctrl), .req_offset(req_offset), .req_src(req_src),
        .fn_state(fn_state),
        .cfg_max_we(cfg_max_we), .cfg_max_len(cfg_max_len),
        .rgn_space(rgn_space), .rgn_offset(rgn_offset), .rgn_len(rgn_len),
        .rgn_ok(rgn_ok),
        .src_idx(src_idx), .src_data(src_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_resp_valid(wr_resp_valid), .wr_resp_err(wr_resp_err),
        .done(done), .done_cc(done_cc), .done_status(done_status), .done_exc(done_exc)
    );

    function automatic logic [63:0] pat(input int i);
        return {32'hA5A5_0000 + 32'(i), 32'h5A5A_0000 + 32'(i) * 32'd7};
    endfunction

    always_comb src_data = pat(int'(src_idx));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nerrors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [63:0] ctrl, input logic [63:0] off,
                                  input logic [63:0] src, input logic [1:0] fs,
                                  input int maxl, input bit rok, input int errb,
                                  output int cc, output int st, output int ex,
                                  output int nwr);
        int ln;
        int sp;
        int beats;
        ln = int'(ctrl[7:0]);
        sp = int'(ctrl[19:16]);
        cc = 0; st = 0; ex = 0; nwr = 0;
        if (!ctrl[63]) cc = 3;
        else if (fs == 2'd1 || fs == 2'd2) begin cc = 1; st = 8'h08; end
        else if (sp > 5) begin cc = 1; st = 8'h0A; end
        else if (off[2:0] != 0 || src[2:0] != 0 || ln <= 8 || (ln % 8) != 0
                 || ln > maxl || int'(off[11:0]) + ln > 4096) ex = 1;
        else if (!rok) ex = 2;
        else begin
            beats = ln / 8;
            if (errb >= 0 && errb < beats) begin nwr = errb + 1; ex = 2; end
            else nwr = beats;
        end
    endfunction

    function automatic string tag_of(input int cc, input int st, input int ex, input int nwr);
        if (cc == 3) return "R2";
        if (st == 8'h08) return "R3";
        if (st == 8'h0A) return "R4";
        if (ex == 1) return "R5";
        if (ex == 2 && nwr == 0) return "R8";
        if (ex == 2) return "R10";
        return "R11";
    endfunction

    task automatic set_max(input int v);
        @(negedge clk);
        cfg_max_we  = 1'b1;
        cfg_max_len = 16'(v);
        @(negedge clk);
        cfg_max_we  = 1'b0;
        model_max   = v;
    endtask

    task automatic run_req(input logic [63:0] ctrl, input logic [63:0] off,
                           input logic [63:0] src, input logic [1:0] fs,
                           input bit rok, input int errb, input string tag);
        int ecc, est, eex, enwr;
        int nseen;
        int guard;
        bit resp_due;
        bit got;
        string t;
        model(ctrl, off, src, fs, model_max, rok, errb, ecc, est, eex, enwr);
        t = (tag.len() != 0) ? tag : tag_of(ecc, est, eex, enwr);
        nseen = 0; resp_due = 0; got = 0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_ctrl   = ctrl;
        req_offset = off;
        req_src    = src;
        fn_state   = fs;
        rgn_ok     = rok;
        guard = 0;
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_ctrl  = ~ctrl;
        // R12: busy after accept; R2: decoded fields on the region outputs
        chk(req_ready == 1'b0, "R12", "ready while busy", longint'(req_ready), 0);
        chk(rgn_space == ctrl[19:16] && rgn_len == ctrl[7:0] && rgn_offset == off,
            "R2", "decoded fields", longint'({rgn_space, rgn_len}),
            longint'({ctrl[19:16], ctrl[7:0]}));
        for (int cyc = 0; cyc < 600; cyc++) begin
            wr_resp_valid = 1'b0;
            wr_resp_err   = 1'b0;
            wr_ready      = 1'b0;
            if (done) begin
                got = 1;
                break;
            end
            if (resp_due) begin
                wr_resp_valid = 1'b1;
                wr_resp_err   = (nseen - 1 == errb);
                resp_due      = 0;
            end else if (wr_valid && ($urandom % 3 != 0)) begin
                wr_ready = 1'b1;
                chk(wr_addr == off + 64'(8 * nseen), "R9", "write address",
                    longint'(wr_addr), longint'(off + 64'(8 * nseen)));
                chk(wr_data == pat(nseen), "R9", "write data",
                    longint'(wr_data), longint'(pat(nseen)));
                nseen++;
                resp_due = 1;
            end
            @(negedge clk);
        end
        chk(got, "R12", "done seen", longint'(got), 1);
        chk(nseen == enwr, "R9", "write count", longint'(nseen), longint'(enwr));
        chk(int'(done_cc) == ecc, t, "cc", longint'(done_cc), longint'(ecc));
        chk(int'(done_status) == est, t, "status", longint'(done_status), longint'(est));
        chk(int'(done_exc) == eex, t, "exception", longint'(done_exc), longint'(eex));
        @(negedge clk);
        chk(done == 1'b0, "R12", "done one cycle", longint'(done), 0);
    endtask

    function automatic logic [63:0] mkc(input bit en, input int sp, input int ln);
        return {en, 31'h0000_1234, 12'h000, 4'(sp), 8'h00, 8'(ln)};
    endfunction

    initial begin
        #750000;
        nchecks++;
        nerrors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20771));
        rst = 1'b1; req_valid = 1'b0; req_ctrl = '0; req_offset = '0; req_src = '0;
        fn_state = 2'd0; cfg_max_we = 1'b0; cfg_max_len = '0; rgn_ok = 1'b1;
        wr_ready = 1'b0; wr_resp_valid = 1'b0; wr_resp_err = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1", "ready after reset", longint'(req_ready), 1);
        chk(done == 1'b0, "R1", "done after reset", longint'(done), 0);
        chk(wr_valid == 1'b0, "R1", "wr_valid after reset", longint'(wr_valid), 0);

        // R11 basic and R6 reset maximum
        run_req(mkc(1, 0, 16), 64'h100, 64'h1000, 2'd0, 1, -1, "R11");
        run_req(mkc(1, 3, 128), 64'h2000, 64'h88, 2'd0, 1, -1, "R6");
        run_req(mkc(1, 3, 136), 64'h2000, 64'h88, 2'd0, 1, -1, "R6");
        // R2 disabled handle outranks everything
        run_req(mkc(0, 7, 12), 64'h5, 64'h3, 2'd1, 0, -1, "R2");
        // R3 blocked states outrank space and spec; offline passes
        run_req(mkc(1, 7, 12), 64'h5, 64'h0, 2'd2, 1, -1, "R3");
        run_req(mkc(1, 0, 16), 64'h0, 64'h0, 2'd1, 1, -1, "R3");
        run_req(mkc(1, 0, 16), 64'h40, 64'h0, 2'd3, 1, -1, "R3");
        // R4 space outranks spec; space 5 allowed
        run_req(mkc(1, 6, 12), 64'h4, 64'h0, 2'd0, 1, -1, "R4");
        run_req(mkc(1, 5, 24), 64'h8, 64'h0, 2'd0, 1, -1, "R4");
        // R5 specification cases
        run_req(mkc(1, 0, 8), 64'h0, 64'h0, 2'd0, 1, -1, "R5");
        run_req(mkc(1, 0, 20), 64'h0, 64'h0, 2'd0, 1, -1, "R5");
        run_req(mkc(1, 0, 16), 64'h4, 64'h0, 2'd0, 1, -1, "R5");
        run_req(mkc(1, 0, 16), 64'h0, 64'h1004, 2'd0, 1, -1, "R5");
        // R7 page boundary
        run_req(mkc(1, 1, 128), 64'h3F80, 64'h0, 2'd0, 1, -1, "R7");
        run_req(mkc(1, 1, 128), 64'h3F88, 64'h0, 2'd0, 1, -1, "R7");
        // R8 region invalid, and spec outranks it
        run_req(mkc(1, 2, 32), 64'h0, 64'h0, 2'd0, 0, -1, "R8");
        run_req(mkc(1, 2, 32), 64'h2, 64'h0, 2'd0, 0, -1, "R8");
        // R10 error mid block and on first beat
        run_req(mkc(1, 4, 64), 64'h800, 64'h0, 2'd0, 1, 2, "R10");
        run_req(mkc(1, 4, 64), 64'h800, 64'h0, 2'd0, 1, 0, "R10");
        // R6 programmed maximum
        set_max(200);
        run_req(mkc(1, 0, 136), 64'h0, 64'h0, 2'd0, 1, -1, "R6");
        run_req(mkc(1, 0, 208), 64'h0, 64'h0, 2'd0, 1, -1, "R6");
        set_max(16);
        run_req(mkc(1, 0, 24), 64'h0, 64'h0, 2'd0, 1, -1, "R6");
        run_req(mkc(1, 0, 16), 64'h0, 64'h0, 2'd0, 1, -1, "R6");
        set_max(128);

        for (int n = 0; n < 300; n++) begin
            logic [63:0] c, o, s;
            logic [1:0]  fs;
            int          ln, sp, eb;
            bit          rk;
            ln = ($urandom % 6 == 0) ? int'($urandom % 256) : 8 * int'($urandom % 17 + 1);
            sp = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 6);
            c  = {($urandom % 8 != 0) ? 1'b1 : 1'b0, 31'($urandom), 12'($urandom),
                  4'(sp), 8'($urandom), 8'(ln)};
            o  = {32'($urandom), 32'($urandom)};
            if ($urandom % 6 != 0) o[2:0] = 3'b000;
            s  = {32'($urandom), 32'($urandom)};
            if ($urandom % 6 != 0) s[2:0] = 3'b000;
            fs = ($urandom % 5 == 0) ? 2'($urandom) : 2'd0;
            rk = ($urandom % 10 != 0);
            eb = ($urandom % 4 == 0) ? int'($urandom % 17) : -1;
            run_req(c, o, s, fs, rk, eb, "");
        end

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end
endmodule